// File: doc/BRIEF.md
# Receive Character Buffer with Per-Entry Error Tags

This block sits behind a serial receiver and holds up to three received characters. Each character is stored together with three error tags: a parity error, a framing error and a break indication. A consumer pops the oldest character with a read strobe. The error status that goes with it can be shown in one of two ways. In per-character mode, only the tags of the entry at the head are shown. In accumulated mode, the tags of every entry consumed since the last clear are ORed with the tags of the present head.

When all three positions are taken, one more completed character is parked in a pending stage, which stands in for the receiver's shift register. That character enters the buffer in the same cycle as the next pop. If the receiver reports a new start bit while a character is parked and no pop happens in that cycle, the parked character is dropped and a sticky overrun flag is raised. The overrun flag and the accumulated status are both cleared by an error-clear strobe.

Top module: `rx_err_fifo`

## Requirements
- R1: The buffer holds up to 3 characters and returns them oldest first. A character offered while fewer than 3 are held, or in the same cycle as a pop, is stored after the present contents.
- R2: `ready_o` is 1 exactly when at least one character is held. `full_o` is 1 exactly when all 3 positions are held.
- R3: `rd_data_o` shows the head character, zero-extended, while the buffer is not empty, and shows zero while it is empty. A strobe on `rd_i` removes the head at the next clock edge. A strobe while empty changes nothing.
- R4: The three tags arrive with the character and are stored with it. With `block_mode_i` at 0, `stat_par_o`, `stat_frm_o` and `stat_brk_o` equal the head entry's tags, and they are 0 while the buffer is empty.
- R5: With `block_mode_i` at 1, each status output is the OR of that tag over every entry popped since the last clear, together with the present head's tag if the buffer is not empty. Neither the status outputs nor the mode input ever pop an entry.
- R6: `clr_err_i` clears the accumulated tags and the overrun flag at the next edge. A pop in the same cycle still contributes its head's tags, and an overrun detected in the same cycle still sets the flag.
- R7: A character completed while the buffer is full and no pop occurs is parked. In the next cycle with a pop, the parked character moves into the buffer, behind the entries already there.
- R8: A start pulse while a character is parked and no pop occurs in that cycle discards the parked character and sets `ovr_o` from the next edge. `ovr_o` then holds until cleared. A start pulse with nothing parked has no effect on `ovr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | Completed character strobe from the receiver |
| char_data_i | input | DATA_W | Completed character |
| par_err_i | input | 1 | Parity error tag for the character |
| frm_err_i | input | 1 | Framing error tag for the character |
| brk_i | input | 1 | Break tag for the character |
| start_det_i | input | 1 | Start-bit detected pulse from the receiver |
| rd_i | input | 1 | Pop the head character |
| block_mode_i | input | 1 | 0: per-character status, 1: accumulated status |
| clr_err_i | input | 1 | Clear accumulated status and overrun |
| rd_data_o | output | DATA_W | Head character, zero when empty |
| stat_par_o | output | 1 | Reported parity error |
| stat_frm_o | output | 1 | Reported framing error |
| stat_brk_o | output | 1 | Reported break |
| ready_o | output | 1 | At least one character held |
| full_o | output | 1 | All positions held |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach is the overrun. It needs a full buffer, then a fourth character parked in the pending stage, then a start pulse in a cycle with no pop. A plain stream of characters never lines those up. The directed part of the stimulus therefore fills the buffer without reading, parks a fourth character, and then does two things: it pops in the same cycle as a start pulse to show that the parked character survives, and it issues a start pulse on its own to show that the parked character is discarded. A long random phase then mixes strobes so that pops, pending moves, clears and mode changes coincide.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;
  typedef struct packed {
    logic par;
    logic frm;
    logic brk;
  } err_t;
  localparam int unsigned ERR_W = $bits(err_t);
endpackage

// File: rtl/rx_err_fifo_store.sv
module rx_err_fifo_store #(
  parameter int unsigned W     = 11,
  parameter int unsigned DEPTH = 3,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= inc(rd_ptr_q);
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[g] <= '0;
      else if (push_i && wr_ptr_q == PTR_W'(g))        mem_q[g] <= push_data_i;
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/rx_err_fifo_hold.sv
module rx_err_fifo_hold #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         char_valid_i,
  input  logic [W-1:0] char_i,
  input  logic         start_det_i,
  input  logic         full_i,
  input  logic         pop_i,
  input  logic         clr_i,
  output logic         push_o,
  output logic [W-1:0] push_data_o,
  output logic         hold_valid_o,
  output logic         ovr_o
);
  logic         hold_valid_q, ovr_q;
  logic [W-1:0] hold_q;
  logic         from_hold, from_in, park, kill;

  assign from_hold = hold_valid_q & pop_i;
  assign from_in   = char_valid_i & ~from_hold & (~full_i | pop_i);
  assign park      = char_valid_i & ~from_in;
  // start of a new character reuses the shift stage
  assign kill      = start_det_i & hold_valid_q & ~pop_i;

  assign push_o      = from_hold | from_in;
  assign push_data_o = from_hold ? hold_q : char_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_valid_q <= 1'b0;
      hold_q       <= '0;
      ovr_q        <= 1'b0;
    end else begin
      hold_valid_q <= park | (hold_valid_q & ~from_hold & ~kill);
      if (park) hold_q <= char_i;
      ovr_q <= kill | (ovr_q & ~clr_i);
    end
  end

  assign hold_valid_o = hold_valid_q;
  assign ovr_o        = ovr_q;
endmodule

// File: rtl/rx_err_fifo_stat.sv
module rx_err_fifo_stat
  import rx_err_fifo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic block_mode_i,
  input  logic clr_i,
  input  logic pop_i,
  input  logic empty_i,
  input  err_t head_err_i,
  output err_t stat_o
);
  err_t acc_q, head_vis;

  assign head_vis = empty_i ? err_t'('0) : head_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= (clr_i ? err_t'('0) : acc_q) | (pop_i ? head_err_i : err_t'('0));
  end

  assign stat_o = block_mode_i ? (acc_q | head_vis) : head_vis;
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              brk_i,
  input  logic              start_det_i,
  input  logic              rd_i,
  input  logic              block_mode_i,
  input  logic              clr_err_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              stat_par_o,
  output logic              stat_frm_o,
  output logic              stat_brk_o,
  output logic              ready_o,
  output logic              full_o,
  output logic              ovr_o
);
  localparam int unsigned W     = DATA_W + ERR_W;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     in_ent, push_ent, head_ent;
  logic [CNT_W-1:0] count;
  logic             push, pop, empty, full, hold_valid;
  err_t             stat;

  assign in_ent = {char_data_i, par_err_i, frm_err_i, brk_i};
  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign pop    = rd_i & ~empty;

  rx_err_fifo_hold #(.W(W)) u_hold (
    .clk_i, .rst_ni,
    .char_valid_i, .char_i(in_ent), .start_det_i,
    .full_i(full), .pop_i(pop), .clr_i(clr_err_i),
    .push_o(push), .push_data_o(push_ent),
    .hold_valid_o(hold_valid), .ovr_o
  );

  rx_err_fifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i(push), .push_data_i(push_ent), .pop_i(pop),
    .head_o(head_ent), .count_o(count)
  );

  rx_err_fifo_stat u_stat (
    .clk_i, .rst_ni,
    .block_mode_i, .clr_i(clr_err_i), .pop_i(pop), .empty_i(empty),
    .head_err_i(err_t'(head_ent[ERR_W-1:0])), .stat_o(stat)
  );

  assign rd_data_o  = empty ? '0 : head_ent[W-1:ERR_W];
  assign stat_par_o = stat.par;
  assign stat_frm_o = stat.frm;
  assign stat_brk_o = stat.brk;
  assign ready_o    = ~empty;
  assign full_o     = full;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              char_valid_i,
  input logic              start_det_i,
  input logic              rd_i,
  input logic              clr_err_i,
  input logic              block_mode_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              stat_par_o,
  input logic              stat_frm_o,
  input logic              stat_brk_o,
  input logic              ready_o,
  input logic              full_o,
  input logic              ovr_o,
  input logic              hold_valid
);
  a_r2_full_implies_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> ready_o);
  a_r1_char_makes_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_i |=> ready_o);
  a_r3_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (rd_data_o == '0));
  a_r4_empty_no_char_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !block_mode_i) |-> !(stat_par_o | stat_frm_o | stat_brk_o));
  a_r7_pending_only_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_valid |-> full_o);
  a_r8_ovr_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovr_o ##1 ovr_o) |-> $past(start_det_i));
  a_r8_ovr_on_kill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_valid && start_det_i && !rd_i) |=> ovr_o);
  a_r6_clear_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_i && !start_det_i) |=> !ovr_o);
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .char_valid_i, .start_det_i, .rd_i, .clr_err_i, .block_mode_i,
  .rd_data_o, .stat_par_o, .stat_frm_o, .stat_brk_o, .ready_o, .full_o, .ovr_o,
  .hold_valid
);

// File: tb/rx_err_fifo_test.sv
module rx_err_fifo_test;
  localparam int PERIOD = 10;
  localparam int DW = 8;
  localparam int DEPTH = 3;

  logic clk = 0, rst_n = 0;
  logic cv = 0, par = 0, frm = 0, brk = 0, st = 0, rd = 0, bm = 0, clr = 0;
  logic [DW-1:0] cd = '0;
  logic [DW-1:0] rdata;
  logic sp, sf, sb, rdy, ful, ovr;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R2";

  always #(PERIOD/2) clk = ~clk;

  rx_err_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(cv), .char_data_i(cd),
    .par_err_i(par), .frm_err_i(frm), .brk_i(brk), .start_det_i(st),
    .rd_i(rd), .block_mode_i(bm), .clr_err_i(clr),
    .rd_data_o(rdata), .stat_par_o(sp), .stat_frm_o(sf), .stat_brk_o(sb),
    .ready_o(rdy), .full_o(ful), .ovr_o(ovr)
  );

  // reference model: entry = {data, par, frm, brk}
  logic [DW+2:0] q[$];
  logic [DW+2:0] m_hold = '0;
  bit m_hv = 0, m_ovr = 0;
  logic [2:0] m_acc = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_hv = 0; m_ovr = 0; m_acc = '0;
    end else begin
      bit popped, kill;
      popped = rd && q.size() != 0;
      kill = st && m_hv && !popped;
      if (clr) m_acc = '0;
      if (popped) begin m_acc |= q[0][2:0]; void'(q.pop_front()); end
      if (m_hv && popped) begin q.push_back(m_hold); m_hv = 0; end
      if (kill) m_hv = 0;
      if (clr) m_ovr = 0;
      if (kill) m_ovr = 1;
      if (cv) begin
        if (q.size() < DEPTH) q.push_back({cd, par, frm, brk});
        else begin m_hold = {cd, par, frm, brk}; m_hv = 1; end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s/%s act=%0h exp=%0h t=%0t", phase, tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [2:0] hf, es;
    hf = (q.size() != 0) ? q[0][2:0] : 3'b0;
    es = bm ? (m_acc | hf) : hf;
    chk("R2_ready", rdy, q.size() != 0);
    chk("R2_full", ful, q.size() == DEPTH);
    chk("R3_data", rdata, (q.size() != 0) ? q[0][DW+2:3] : 0);
    chk(bm ? "R5_status" : "R4_status", {sp, sf, sb}, es);
    chk("R8_ovr", ovr, m_ovr);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); compare();
    cv = 0; st = 0; rd = 0; clr = 0;
  endtask

  task automatic send(logic [DW-1:0] d, logic [2:0] e);
    cv = 1; cd = d; {par, frm, brk} = e; tick();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); compare();           // reset state, R2
    @(negedge clk); rst_n = 1;
    tick();
    phase = "R3"; rd = 1; tick();        // empty read: no change
    phase = "R1";
    send(8'hA1, 3'b100); send(8'hB2, 3'b010); send(8'hC3, 3'b001);
    phase = "R7"; send(8'hD4, 3'b000);   // parked
    rd = 1; tick();                      // D4 moves in
    phase = "R1"; rd = 1; tick(); rd = 1; tick();
    phase = "R4"; tick();
    phase = "R8"; rd = 1; tick();
    send(8'h11, 3'b000); send(8'h22, 3'b111); send(8'h33, 3'b000);
    send(8'h44, 3'b110);                 // parked
    st = 1; rd = 1; tick();              // pop same cycle: no overrun
    send(8'h55, 3'b011);                 // parked again
    st = 1; tick();                      // discard, overrun
    send(8'h66, 3'b000); tick();
    phase = "R5"; bm = 1;
    rd = 1; tick(); rd = 1; tick(); tick();
    phase = "R6"; clr = 1; tick(); tick();
    clr = 1; rd = 1; tick();
    rd = 1; tick(); rd = 1; tick(); bm = 0; tick();
    phase = "RND";
    for (int i = 0; i < 4000; i++) begin
      cv = ($urandom % 3) == 0; cd = DW'($urandom);
      {par, frm, brk} = 3'($urandom);
      st = ($urandom % 4) == 0; rd = ($urandom % 4) == 0;
      clr = ($urandom % 16) == 0;
      if (i % 200 == 0) bm = ~bm;
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule